// File: doc/BRIEF.md
# TDM Serial Data Transmitter

This block places parallel audio words onto a single time-division-multiplexed serial data line. An external bit clock and frame sync set the timing. Both are brought into the block's system clock domain and turned into one-cycle edge events. At every frame start the block captures one word per slot together with a slot-enable mask. It then sends the enabled slots MSB first, one bit per bit clock, starting a programmable number of bit clocks after the frame start. The output is a data bit plus an output enable, so the pad can release the line.

An 8-bit configuration register with a write strobe sets the behaviour:

- which bit-clock edge launches data;
- the lead offset from frame start to slot 0;
- whether bit positions outside enabled slots are driven low or released;
- whether each slot's LSB is driven for a whole bit period or only half of one.

A keeper mode models a line-hold circuit. The block reports the hold request and the level to hold, and the pad circuit does the holding. A frame sync that arrives early abandons the current frame and restarts counting.

Top module: `tdm_tx_serializer`

## Requirements
- R1: After reset the register value is 0x13 and outputs `sd_oe`, `sd_out` and `keep_hold` are 0. Register bits are [7] half-LSB, [6] keep-always, [5] keep-enable, [4] release-fill, [3:1] lead offset and [0] launch-on-falling. The reset value therefore means offset 1, falling-edge launch, released fill, keeper off and full-period LSB.
- R2: The outputs change only on the bit-clock edge chosen by bit [0], or on the opposite edge when that edge ends a half-period LSB or a one-bit hold. Bit [0] = 0 selects rising and 1 selects falling.
- R3: A frame starts at the first launch edge where the frame sync is sampled high after being low. That launch carries position 0, and the MSB of slot 0 is sent at position equal to the offset field (0 to 7).
- R4: Slot g takes `slot_data[g*SLOT_W +: SLOT_W]`, and slots are sent in ascending order, MSB first, back to back. Data and enables are captured at frame start, so later changes to the inputs do not alter the frame in flight.
- R5: Positions inside the lead offset, inside disabled slots, or after the last slot give `sd_oe`=1 and `sd_out`=0 when bit [4]=0. When bit [4]=1 they give `sd_oe`=0.
- R6: With the keeper off, a slot LSB stays driven for the full bit period when bit [7]=0. When bit [7]=1, `sd_oe` drops at the opposite edge within that LSB period.
- R7: With the keeper on (bit [5]=1), every slot LSB is driven for half a period. At the opposite edge `keep_hold` rises and `keep_level` takes the LSB value. With bit [6]=0 the hold ends at the next opposite edge. With bit [6]=1 it stays until the line is driven again.
- R8: `keep_hold` is never 1 while `sd_oe` is 1. Any launch that drives the line clears the hold.
- R9: A frame sync arriving before the frame ends restarts at position 0 with newly captured data, and the partial slot is dropped.
- R10: Whenever `sd_oe` is 0, `sd_out` is 0.
- R11: From reset until the first frame start the line is released, whatever the fill setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| fsync | input | 1 | Frame sync (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| slot_data | input | NUM_SLOTS*SLOT_W | Parallel slot words |
| slot_en | input | NUM_SLOTS | Slot enable mask |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Serial data output enable |
| keep_hold | output | 1 | Line-hold request |
| keep_level | output | 1 | Level to hold |

## Verification
Two functions can act on the same launch edge:

- The capture of new slot words at frame start and the launch of the first data bit can share a cycle. An offset of 0 forces this. The bench judges it by the new MSB appearing at position 0 even though the inputs are scrambled a few bits later.
- A restart can drive the line while an always-on keeper is still holding it. A frame is stopped after a slot LSB has started a hold, and a new frame sync is issued. The first driven bit of the new frame must raise `sd_oe` and drop `keep_hold` on the same edge. The restart checks and the hold-exclusion property both judge this.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // Register layout, MSB to LSB.
  typedef struct packed {
    logic       lsb_half;
    logic       keep_always;
    logic       keep_en;
    logic       fill_hiz;
    logic [2:0] offset;
    logic       launch_fall;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{
    lsb_half:    1'b0,
    keep_always: 1'b0,
    keep_en:     1'b0,
    fill_hiz:    1'b1,
    offset:      3'd1,
    launch_fall: 1'b1
  };

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_DATA = 2'd2,
    PH_TAIL = 2'd3
  } tx_phase_t;

endpackage

// File: rtl/tdm_tx_edge.sv
module tdm_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic fsync,
  input  logic launch_fall,
  output logic launch_ev,
  output logic mid_ev,
  output logic fsync_s
);

  logic [SYNC_STAGES:0]   bclk_sr;
  logic [SYNC_STAGES-1:0] fs_sr;
  logic                   rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sr <= '0;
      fs_sr   <= '0;
    end else begin
      bclk_sr <= {bclk_sr[SYNC_STAGES-1:0], bclk};
      fs_sr   <= {fs_sr[SYNC_STAGES-2:0], fsync};
    end
  end

  assign rise      = bclk_sr[SYNC_STAGES-1] & ~bclk_sr[SYNC_STAGES];
  assign fall      = ~bclk_sr[SYNC_STAGES-1] & bclk_sr[SYNC_STAGES];
  assign launch_ev = launch_fall ? fall : rise;
  assign mid_ev    = launch_fall ? rise : fall;
  assign fsync_s   = fs_sr[SYNC_STAGES-1];

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W     = 16,
  parameter int NUM_SLOTS  = 4,
  parameter int OFFS_W     = 3,
  localparam int BIT_W     = $clog2(SLOT_W),
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch_ev,
  input  logic                  fsync_s,
  input  logic [OFFS_W-1:0]     offset,
  output logic                  frame_start,
  output logic                  seen,
  output logic                  in_data,
  output logic                  is_lsb,
  output logic [SLOT_IDX_W-1:0] cur_slot,
  output logic [BIT_W-1:0]      cur_bit
);

  localparam logic [BIT_W-1:0]      BIT_LAST  = BIT_W'(SLOT_W - 1);
  localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = SLOT_IDX_W'(NUM_SLOTS - 1);

  tx_phase_t             ph_q, nx_ph;
  logic [OFFS_W-1:0]     lead_q, nx_lead;
  logic [BIT_W-1:0]      bit_q, nx_bit;
  logic [SLOT_IDX_W-1:0] slot_q, nx_slot;
  logic                  fs_prev_q, seen_q;

  assign frame_start = launch_ev & fsync_s & ~fs_prev_q;
  assign seen        = seen_q | frame_start;

  // Position of the bit launched on this edge.
  always_comb begin
    nx_ph   = ph_q;
    nx_lead = lead_q;
    nx_bit  = bit_q;
    nx_slot = slot_q;
    if (frame_start) begin
      nx_bit  = '0;
      nx_slot = '0;
      if (offset == '0) begin
        nx_ph   = PH_DATA;
        nx_lead = '0;
      end else begin
        nx_ph   = PH_LEAD;
        nx_lead = offset;
      end
    end else begin
      unique case (ph_q)
        PH_LEAD: begin
          if (lead_q == OFFS_W'(1)) begin
            nx_ph   = PH_DATA;
            nx_lead = '0;
            nx_bit  = '0;
            nx_slot = '0;
          end else begin
            nx_lead = lead_q - 1'b1;
          end
        end
        PH_DATA: begin
          if (bit_q == BIT_LAST) begin
            nx_bit = '0;
            if (slot_q == SLOT_LAST) nx_ph = PH_TAIL;
            else                     nx_slot = slot_q + 1'b1;
          end else begin
            nx_bit = bit_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      lead_q    <= '0;
      bit_q     <= '0;
      slot_q    <= '0;
      fs_prev_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (launch_ev) begin
      ph_q      <= nx_ph;
      lead_q    <= nx_lead;
      bit_q     <= nx_bit;
      slot_q    <= nx_slot;
      fs_prev_q <= fsync_s;
      if (frame_start) seen_q <= 1'b1;
    end
  end

  assign in_data  = (nx_ph == PH_DATA);
  assign is_lsb   = (nx_bit == BIT_LAST);
  assign cur_slot = nx_slot;
  assign cur_bit  = nx_bit;

endmodule

// File: rtl/tdm_tx_slot_buf.sv
module tdm_tx_slot_buf #(
  parameter int SLOT_W      = 16,
  parameter int NUM_SLOTS   = 4,
  localparam int BIT_W      = $clog2(SLOT_W),
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_start,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0]        slot_en,
  input  logic [SLOT_IDX_W-1:0]       cur_slot,
  input  logic [BIT_W-1:0]            cur_bit,
  output logic                        bit_val,
  output logic                        slot_on
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_W - 1);

  logic [SLOT_W-1:0]    word_q   [NUM_SLOTS];
  logic [SLOT_W-1:0]    word_now [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] en_q, en_now;
  logic [SLOT_W-1:0]    sel_word;

  // Words captured at frame start; bypass so the launch at the start sees new data.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (frame_start) word_q[g] <= slot_data[g*SLOT_W +: SLOT_W];
    end
    assign word_now[g] = frame_start ? slot_data[g*SLOT_W +: SLOT_W] : word_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)              en_q <= '0;
    else if (frame_start) en_q <= slot_en;
  end

  assign en_now   = frame_start ? slot_en : en_q;
  assign sel_word = word_now[cur_slot];
  assign bit_val  = sel_word[BIT_LAST - cur_bit];
  assign slot_on  = en_now[cur_slot];

endmodule

// File: rtl/tdm_tx_line.sv
module tdm_tx_line
  import tdm_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    launch_ev,
  input  logic    mid_ev,
  input  tx_cfg_t cfg,
  input  logic    seen,
  input  logic    in_data,
  input  logic    slot_on,
  input  logic    bit_val,
  input  logic    is_lsb,
  output logic    sd_out,
  output logic    sd_oe,
  output logic    keep_hold,
  output logic    keep_level
);

  logic half_pend_q;
  logic hold_short_q;
  logic half_lsb;

  assign half_lsb = cfg.keep_en | cfg.lsb_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_out       <= 1'b0;
      sd_oe        <= 1'b0;
      keep_hold    <= 1'b0;
      keep_level   <= 1'b0;
      half_pend_q  <= 1'b0;
      hold_short_q <= 1'b0;
    end else if (launch_ev) begin
      if (!seen) begin
        sd_oe       <= 1'b0;
        sd_out      <= 1'b0;
        half_pend_q <= 1'b0;
      end else if (in_data && slot_on) begin
        sd_oe       <= 1'b1;
        sd_out      <= bit_val;
        keep_hold   <= 1'b0;
        half_pend_q <= is_lsb & half_lsb;
      end else if (!cfg.fill_hiz) begin
        sd_oe       <= 1'b1;
        sd_out      <= 1'b0;
        keep_hold   <= 1'b0;
        half_pend_q <= 1'b0;
      end else begin
        sd_oe       <= 1'b0;
        sd_out      <= 1'b0;
        half_pend_q <= 1'b0;
      end
    end else if (mid_ev) begin
      if (half_pend_q) begin
        sd_oe       <= 1'b0;
        sd_out      <= 1'b0;
        half_pend_q <= 1'b0;
        if (cfg.keep_en) begin
          keep_hold    <= 1'b1;
          keep_level   <= sd_out;
          hold_short_q <= ~cfg.keep_always;
        end
      end else if (keep_hold && hold_short_q) begin
        keep_hold <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W      = 16,
  parameter int NUM_SLOTS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bclk,
  input  logic                        fsync,
  input  logic                        cfg_we,
  input  logic [7:0]                  cfg_wdata,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0]        slot_en,
  output logic                        sd_out,
  output logic                        sd_oe,
  output logic                        keep_hold,
  output logic                        keep_level
);

  localparam int BIT_W      = $clog2(SLOT_W);
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  tx_cfg_t               cfg_q;
  logic                  launch_ev, mid_ev, fsync_s;
  logic                  frame_start, seen, in_data, is_lsb, bit_val, slot_on;
  logic [SLOT_IDX_W-1:0] cur_slot;
  logic [BIT_W-1:0]      cur_bit;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= tx_cfg_t'(cfg_wdata);
  end

  tdm_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
    .launch_fall(cfg_q.launch_fall),
    .launch_ev(launch_ev), .mid_ev(mid_ev), .fsync_s(fsync_s)
  );

  tdm_tx_framer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .OFFS_W(3)) u_framer (
    .clk(clk), .rst(rst), .launch_ev(launch_ev), .fsync_s(fsync_s),
    .offset(cfg_q.offset), .frame_start(frame_start), .seen(seen),
    .in_data(in_data), .is_lsb(is_lsb), .cur_slot(cur_slot), .cur_bit(cur_bit)
  );

  tdm_tx_slot_buf #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_buf (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .slot_data(slot_data), .slot_en(slot_en),
    .cur_slot(cur_slot), .cur_bit(cur_bit),
    .bit_val(bit_val), .slot_on(slot_on)
  );

  tdm_tx_line u_line (
    .clk(clk), .rst(rst), .launch_ev(launch_ev), .mid_ev(mid_ev),
    .cfg(cfg_q), .seen(seen), .in_data(in_data), .slot_on(slot_on),
    .bit_val(bit_val), .is_lsb(is_lsb),
    .sd_out(sd_out), .sd_oe(sd_oe), .keep_hold(keep_hold), .keep_level(keep_level)
  );

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
  input logic clk,
  input logic rst,
  input logic launch_ev,
  input logic mid_ev,
  input logic sd_out,
  input logic sd_oe,
  input logic keep_hold,
  input logic keep_level
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sd_oe && !keep_hold));

  assert_change_on_edges_R2: assert property (@(posedge clk) disable iff (rst)
    (!launch_ev && !mid_ev) |=> ($stable(sd_out) && $stable(sd_oe) &&
                                 $stable(keep_hold) && $stable(keep_level)));

  assert_hold_starts_mid_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(keep_hold) |-> ($past(mid_ev) && $fell(sd_oe)));

  assert_level_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (keep_hold && $past(keep_hold)) |-> $stable(keep_level));

  assert_hold_excl_drive_R8: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> !keep_hold);

  assert_low_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !sd_oe |-> !sd_out);

endmodule

bind tdm_tx_serializer tdm_tx_checker u_chk (
  .clk(clk), .rst(rst), .launch_ev(launch_ev), .mid_ev(mid_ev),
  .sd_out(sd_out), .sd_oe(sd_oe), .keep_hold(keep_hold), .keep_level(keep_level)
);

// File: tb/tb_tdm_tx_serializer.sv
module tb_tdm_tx_serializer;

  localparam int W  = 16;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          bclk = 1'b0;
  logic          fsync = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [NS*W-1:0] slot_data = '0;
  logic [NS-1:0] slot_en = '0;
  logic          sd_out, sd_oe, keep_hold, keep_level;

  always #5 clk = ~clk;

  tdm_tx_serializer #(.SLOT_W(W), .NUM_SLOTS(NS)) dut (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .slot_data(slot_data), .slot_en(slot_en),
    .sd_out(sd_out), .sd_oe(sd_oe), .keep_hold(keep_hold), .keep_level(keep_level)
  );

  // {write, cfg[7:0], en[1:0], data[31:0]}
  localparam logic [42:0] VEC [8] = '{
    {1'b0, 8'h13, 2'b11, 32'hA5C3_1E7F},
    {1'b1, 8'h00, 2'b11, 32'h8001_FFFE},
    {1'b1, 8'h0E, 2'b01, 32'h1234_5678},
    {1'b1, 8'h93, 2'b10, 32'h0001_0001},
    {1'b1, 8'h33, 2'b01, 32'h0003_FFFF},
    {1'b1, 8'h72, 2'b01, 32'h0000_C001},
    {1'b1, 8'h25, 2'b11, 32'h5555_AAAB},
    {1'b1, 8'hF4, 2'b11, 32'h7FFF_0001}
  };

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   sim_done = 0;
  logic [7:0] e_cfg = 8'h13;
  logic m_oe, m_sd, m_hold, m_level, m_short, m_pend;

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag);
    n_checks++;
    if (sd_oe !== m_oe || sd_out !== m_sd || keep_hold !== m_hold ||
        (m_hold && keep_level !== m_level)) begin
      n_fail++;
      $display("FAIL %s: oe,sd,hold,level actual %b%b%b%b expected %b%b%b%b",
               tag, sd_oe, sd_out, keep_hold, keep_level, m_oe, m_sd, m_hold, m_level);
    end
    if (!m_oe) begin
      n_checks++;
      if (sd_out !== 1'b0) begin
        n_fail++;
        $display("FAIL R10: sd_out actual %b expected 0 while released", sd_out);
      end
    end
  endtask

  task automatic setup(input bit wr, input logic [7:0] c);
    e_cfg = wr ? c : 8'h13;
    bclk  = e_cfg[0];
    fsync = 1'b0;
    wait_clks(4);
    rst = 1'b1;
    wait_clks(3);
    rst = 1'b0;
    {m_oe, m_sd, m_hold, m_level, m_short, m_pend} = '0;
    if (wr) begin
      cfg_we = 1'b1; cfg_wdata = c;
      wait_clks(1);
      cfg_we = 1'b0;
    end
    wait_clks(4);
  endtask

  task automatic run_frame(input logic [31:0] data, input logic [1:0] en,
                           input int nbits, input string force_tag);
    int    off;
    string tag;
    off       = int'(e_cfg[3:1]);
    slot_data = data;
    slot_en   = en;
    fsync     = 1'b1;
    wait_clks(4);
    for (int p = 0; p < nbits; p++) begin
      int rel, s, b;
      bit used, had_hold;
      rel = p - off;
      s   = (rel >= 0) ? rel / W : 0;
      b   = (rel >= 0) ? rel % W : 0;
      used = (p >= off) && (rel < NS*W) && en[s];
      had_hold = m_hold;
      bclk = ~e_cfg[0];
      wait_clks(4);
      if (used) begin
        m_oe = 1; m_sd = data[s*W + (W-1-b)]; m_hold = 0;
        m_pend = (b == W-1) && (e_cfg[5] || e_cfg[7]);
        tag = had_hold ? "R8" : "R4";
      end else if (!e_cfg[4]) begin
        m_oe = 1; m_sd = 0; m_hold = 0; m_pend = 0;
        tag = (p < off) ? "R3" : "R5";
      end else begin
        m_oe = 0; m_sd = 0; m_pend = 0;
        tag = (p < off) ? "R3" : "R5";
      end
      chk(force_tag != "" ? force_tag : tag);
      bclk = e_cfg[0];
      if (p == 0) fsync = 1'b0;
      if (p == 4) begin slot_data = ~data; slot_en = ~en; end
      wait_clks(4);
      tag = "R2";
      if (m_pend) begin
        if (e_cfg[5]) begin
          m_hold = 1; m_level = m_sd; m_short = ~e_cfg[6];
          tag = "R7";
        end else tag = "R6";
        m_oe = 0; m_sd = 0; m_pend = 0;
      end else if (m_hold && m_short) begin
        m_hold = 0;
        tag = "R7";
      end
      chk(force_tag != "" ? force_tag : tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!sim_done) begin
      n_fail++;
      $display("FAIL R2: watchdog expired, actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with the default register
    setup(1'b0, 8'h00);
    chk("R1");

    // Table walk; R1 default config used by entry 0
    for (int v = 0; v < 8; v++) begin
      setup(VEC[v][42], VEC[v][41:34]);
      run_frame(VEC[v][31:0], VEC[v][33:32], 43, "");
    end

    // R11: no frame sync yet, fill low, line stays released
    setup(1'b1, 8'h00);
    slot_en = 2'b11; slot_data = 32'hFFFF_FFFF;
    for (int p = 0; p < 4; p++) begin
      bclk = 1'b1; wait_clks(4); chk("R11");
      bclk = 1'b0; wait_clks(4); chk("R11");
    end

    // R9: early frame sync restarts with new data
    setup(1'b1, 8'h00);
    run_frame(32'h0F0F_3C3C, 2'b11, 10, "");
    run_frame(32'hC3A5_9696, 2'b11, 40, "R9");

    // R9 with always-on keeper holding when the restart arrives (R8 on first drive)
    setup(1'b1, 8'h72);
    run_frame(32'h0000_4001, 2'b01, 20, "");
    run_frame(32'h0000_8000, 2'b01, 36, "R9");

    sim_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule